// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus. It holds a small bank of 8-bit configuration registers, for example the enable bits of a clock generator's outputs. It runs on a system clock that is much faster than the serial clock. Both bus lines pass through two-flop synchronizers inside the block. It pulls SDA low through an open-drain enable output, and the full register bank is always visible as one flat parallel vector.

The first byte after the address is a command byte. When bit 7 of the command is set, the access is a single indexed byte, and bits 6:0 give the register offset. When bit 7 is clear, the access is a block transfer starting at register 0:

- A block write carries a byte count and then the data bytes.
- A block read first returns the register count and then the data bytes.

Every register comes up at its parameterised default, so a system that never touches the bus still gets a usable setup.

Top module: `twowire_cfg_slave`

## Requirements
- R1: The block answers only the 7-bit address 1101001, that is address byte D2h for write and D3h for read. For any other address byte it gives no acknowledge and never drives SDA.
- R2: After reset, `regs_o` equals `RST_VAL` (default C3h in every register) and `sda_oe` is 0.
- R3: Byte write is address D2h, then command {1, offset[6:0]}, then one data byte. Register `offset` takes the data byte, and every other byte of `regs_o` keeps its value. All three bytes are acknowledged.
- R4: Byte read is address D2h, command {1, offset}, a repeated start and address D3h. The block then returns the register at `offset`, most significant bit first.
- R5: Block write is address D2h, command 00h, a count byte whose value is ignored, and then data bytes. The data bytes land in registers 0, 1, 2 and so on. A stop after any complete byte keeps the bytes already sent.
- R6: Block read is address D2h, command 00h, a repeated start and address D3h. The block returns NREG first, then registers 0 upward. After the master's not-acknowledge, `sda_oe` is 0.
- R7: Writes whose offset or block position is NREG or higher are acknowledged and discarded. Reads there return 00h.
- R8: `sda_oe` changes only while SCL is low. The acknowledge holds SDA low for the ninth SCL clock of each received byte.
- R9: A start or stop arriving in the middle of a byte aborts the transfer. The partial byte never reaches `regs_o`, and the next transfer works normally. `regs_o` changes only when the eighth bit of a data byte is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| regs_o | output | NREG*8 | Register bank, register i at bits 8i+7:8i |

## Verification
The test sequence uses several kinds of bus traffic, each aimed at a different part of the decode:

- Foreign and near-miss addresses separate real address decoding from a partial match.
- Indexed writes and reads at different offsets show that the offset comes from the command byte.
- A full block write, followed by a block read, shows that the count prefix and the ascending register order are handled.
- A block write that is cut short shows that each byte is committed on its own.
- Out-of-range offsets and over-long block writes check the discard path.
- Stops and repeated starts inserted in the middle of a byte check the abort path and that recovery afterwards is clean.

// File: rtl/twowire_cfg_slave.sv
module twowire_cfg_slave #(
  parameter int NREG = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] RST_VAL = {NREG{8'hC3}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {B_ADDR, B_CMD, B_CNT, B_DATA} role_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_d, sda_d;
  st_t        st;
  role_t      role;
  logic [2:0] bitcnt;
  logic [7:0] sh, ptr, rd_byte, next_tx;
  logic [1:0] ph;
  logic       blk, rd_dir, oe_q;
  logic [NREG*8-1:0] regs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_d <= scl_s[1];
      sda_d <= sda_s[1];
    end

  wire scl      = scl_s[1];
  wire sda      = sda_s[1];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire [7:0] byte_in = {sh[6:0], sda};
  wire byte_done = (st == S_RX) && scl_rise && (bitcnt == 3'd7);
  wire wr_en = byte_done && (role == B_DATA) && !rd_dir;

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == 8'(i)) rd_byte = regs_q[i*8 +: 8];
    next_tx = (role == B_CNT) ? 8'(NREG) : rd_byte;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; role <= B_ADDR; bitcnt <= '0; sh <= '0; ptr <= '0;
      ph <= '0; blk <= 1'b0; rd_dir <= 1'b0; oe_q <= 1'b0;
    end else if (start_c) begin
      st <= S_RX; role <= B_ADDR; bitcnt <= '0; ph <= '0; oe_q <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; oe_q <= 1'b0;
    end else begin
      case (st)
        S_RX: if (scl_rise) begin
          sh <= byte_in;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            st <= S_RACK; ph <= '0;
            case (role)
              B_ADDR:
                if (byte_in[7:1] == DEV_ADDR) begin
                  rd_dir <= byte_in[0];
                  role <= byte_in[0] ? (blk ? B_CNT : B_DATA) : B_CMD;
                end else st <= S_IDLE;
              B_CMD: begin
                blk  <= ~byte_in[7];
                ptr  <= byte_in[7] ? {1'b0, byte_in[6:0]} : 8'h00;
                role <= byte_in[7] ? B_DATA : B_CNT;
              end
              B_CNT: role <= B_DATA;
              default: if (ptr != 8'hFF) ptr <= ptr + 8'd1;
            endcase
          end
        end
        S_RACK: if (scl_fall) begin
          if (ph == 2'd0) begin
            ph <= 2'd1; oe_q <= 1'b1;
          end else begin
            ph <= 2'd0; bitcnt <= '0;
            if (rd_dir) begin
              st <= S_TX; sh <= next_tx; oe_q <= ~next_tx[7];
              if (role == B_CNT) role <= B_DATA;
              else if (ptr != 8'hFF) ptr <= ptr + 8'd1;
            end else begin
              st <= S_RX; oe_q <= 1'b0;
            end
          end
        end
        S_TX:
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin st <= S_MACK; ph <= '0; end
          end else if (scl_fall) begin
            sh <= {sh[6:0], 1'b0}; oe_q <= ~sh[6];
          end
        S_MACK:
          if (ph == 2'd0 && scl_fall) begin
            oe_q <= 1'b0; ph <= 2'd1;
          end else if (ph == 2'd1 && scl_rise) begin
            if (sda) st <= S_IDLE;
            else ph <= 2'd2;
          end else if (ph == 2'd2 && scl_fall) begin
            st <= S_TX; bitcnt <= '0; sh <= next_tx; oe_q <= ~next_tx[7];
            if (role == B_CNT) role <= B_DATA;
            else if (ptr != 8'hFF) ptr <= ptr + 8'd1;
          end
        default: oe_q <= 1'b0;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) regs_q <= RST_VAL;
    else
      for (int i = 0; i < NREG; i++)
        if (wr_en && ptr == 8'(i)) regs_q[i*8 +: 8] <= byte_in;

  assign sda_oe = oe_q;
  assign regs_o = regs_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe_q) |-> !scl); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE) |-> !oe_q); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) stop_c |=> (st == S_IDLE)); // R9
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n) start_c |=> (st == S_RX && role == B_ADDR && bitcnt == 3'd0)); // R9
  AST_REGS_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (regs_q != $past(regs_q)) |-> $past(byte_done)); // R9

endmodule

// File: tb/sim_twowire_cfg_slave.sv
module sim_twowire_cfg_slave;
  localparam int NREG = 8;
  localparam logic [NREG*8-1:0] RSTV = {NREG{8'hC3}};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire sda_bus = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  twowire_cfg_slave #(.NREG(NREG)) u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl_m),
    .sda_in(sda_bus), .sda_oe(sda_oe), .regs_o(regs_o));

  int checks = 0, fails = 0, oe_bad = 0, oe_edges = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] exp_q[$], got_q[$];
  logic prev_oe = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  function automatic logic [NREG*8-1:0] mvec();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic qd(); repeat (10) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; scl_m = 1; qd(); sda_m = 0; qd(); scl_m = 0; qd(); endtask
  task automatic i2c_rstart(); sda_m = 1; qd(); scl_m = 1; qd(); sda_m = 0; qd(); scl_m = 0; qd(); endtask
  task automatic i2c_stop(); sda_m = 0; qd(); scl_m = 1; qd(); sda_m = 1; qd(); endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qd(); scl_m = 1; qd(); qd(); scl_m = 0; qd();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; qd(); scl_m = 1; qd(); ack = !sda_bus; qd(); scl_m = 0; qd();
  endtask

  task automatic send_chk(input logic [7:0] b, input bit want, input string tag);
    bit a;
    send_byte(b, a);
    chk(a == want, tag, 64'(a), 64'(want));
  endtask

  task automatic recv_byte(input bit mack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; qd(); scl_m = 1; qd(); b[i] = sda_bus; qd(); scl_m = 0; qd();
    end
    got_q.push_back(b);
    sda_m = !mack; qd(); scl_m = 1; qd(); qd(); scl_m = 0; qd(); sda_m = 1;
  endtask

  task automatic wr_op(input logic [6:0] off, input logic [7:0] val, input string tag);
    i2c_start(); send_chk(8'hD2, 1, tag); send_chk({1'b1, off}, 1, tag);
    send_chk(val, 1, tag); i2c_stop();
    if (off < NREG) mdl[off] = val;
    repeat (4) @(negedge clk);
    chk(regs_o == mvec(), tag, regs_o, mvec());
  endtask

  task automatic rd_op(input logic [6:0] off, input string tag);
    i2c_start(); send_chk(8'hD2, 1, tag); send_chk({1'b1, off}, 1, tag);
    i2c_rstart(); send_chk(8'hD3, 1, tag);
    exp_q.push_back(off < NREG ? mdl[off] : 8'h00);
    recv_byte(0); i2c_stop();
  endtask

  task automatic blk_wr(input int nb, input logic [7:0] seed, input string tag);
    i2c_start(); send_chk(8'hD2, 1, tag); send_chk(8'h00, 1, tag);
    send_chk(8'(nb), 1, tag);
    for (int i = 0; i < nb; i++) begin
      send_chk(seed + 8'(i * 17), 1, tag);
      if (i < NREG) mdl[i] = seed + 8'(i * 17);
    end
    i2c_stop(); repeat (4) @(negedge clk);
    chk(regs_o == mvec(), tag, regs_o, mvec());
  endtask

  task automatic blk_rd();
    i2c_start(); send_chk(8'hD2, 1, "R6 addr"); send_chk(8'h00, 1, "R6 cmd");
    i2c_rstart(); send_chk(8'hD3, 1, "R6 raddr");
    exp_q.push_back(8'(NREG)); recv_byte(1);
    for (int i = 0; i < NREG; i++) begin
      exp_q.push_back(mdl[i]); recv_byte(i != NREG - 1);
    end
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 release after nack", 64'(sda_oe), 64'd0);
    i2c_stop();
  endtask

  // scoreboard monitor: pairs received bytes with expected ones
  initial forever begin
    @(negedge clk);
    if (got_q.size() > 0) begin
      logic [7:0] g, e;
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk(0, "R4/R6/R7 unexpected byte", 64'(g), 64'h0);
      else begin e = exp_q.pop_front(); chk(g == e, "R4/R6/R7 read byte", 64'(g), 64'(e)); end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (sda_oe !== prev_oe) begin oe_edges++; if (scl_m) oe_bad++; end
    prev_oe = sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = 8'hC3;
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    chk(regs_o == RSTV, "R2 reset regs", regs_o, RSTV);
    chk(sda_oe == 1'b0, "R2 reset sda_oe", 64'(sda_oe), 64'd0);

    i2c_start(); send_chk(8'hA0, 0, "R1 foreign address"); i2c_stop();
    i2c_start(); send_chk(8'hD4, 0, "R1 near-miss address"); i2c_stop();
    chk(regs_o == mvec(), "R1 regs untouched", regs_o, mvec());

    wr_op(7'd3, 8'h5A, "R3 byte write 3");
    wr_op(7'd0, 8'h11, "R3 byte write 0");
    rd_op(7'd3, "R4 read 3");
    rd_op(7'd5, "R4 read default 5");

    blk_wr(NREG, 8'h21, "R5 full block write");
    blk_wr(3, 8'hA0, "R5 partial block write");
    blk_rd();

    wr_op(7'h20, 8'h33, "R7 write out of range");
    rd_op(7'h20, "R7 read out of range");
    blk_wr(NREG + 2, 8'h07, "R7 over-long block write");

    i2c_start(); send_chk(8'hD2, 1, "R9 addr"); send_chk(8'h81, 1, "R9 cmd");
    send_bits(8'hFF, 4); i2c_stop(); repeat (4) @(negedge clk);
    chk(regs_o == mvec(), "R9 stop mid-byte", regs_o, mvec());
    i2c_start(); send_chk(8'hD2, 1, "R9 addr"); send_chk(8'h82, 1, "R9 cmd");
    send_bits(8'h00, 5); i2c_rstart();
    send_chk(8'hD2, 1, "R9 addr after restart"); send_chk(8'h82, 1, "R9 cmd after restart");
    send_chk(8'h77, 1, "R9 data after restart"); i2c_stop(); mdl[2] = 8'h77;
    repeat (4) @(negedge clk);
    chk(regs_o == mvec(), "R9 recovery write", regs_o, mvec());

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4/R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
    chk(oe_bad == 0 && oe_edges > 0, "R8 sda_oe moves only with SCL low", 64'(oe_bad), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule